// File: doc/BRIEF.md
# Transmit Slice Time Gate

This block divides transmit airtime among four slices. Each slice runs its own repeating cycle counted in microsecond ticks. Within that cycle the slice has an open window, set by a start offset and an inclusive end value. Each slice also holds a 32-bit destination tag, which is the low 32 bits of a station's 48-bit MAC address. A packet waiting at the head of a queue shows its destination tag. The block returns the slice that owns that tag, and a permit bit that is high only while that slice's window is open. A tag that no slice owns is handled by slice 0.

Software programs the slices through a write port. A write carries a slice index, a field select and a value. The period, start and end of a slice are staged, and they reach the running timer only when that slice's cycle wraps. Writing index 4 is a synchronize command. It restarts every slice counter at zero on the same edge and applies all staged timing at once, so the windows of all slices line up. Each slice timer has three phase states. BEFORE means the count is below start. OPEN means the count lies within start..end. AFTER means the count is beyond end. The transitions are: BEFORE->OPEN when the count reaches start; OPEN->AFTER when the count passes end; AFTER->BEFORE or AFTER->OPEN on a wrap or a synchronize. A slice with start greater than end never enters OPEN.

Top module: `tx_slice_gate`

## Requirements
- R1: After reset, every counter and every timing and tag register is zero, so all four gates read 1 and pkt_slice reads 0.
- R2: A write with wr_slice 0..3 addresses that slice. wr_field 0 stages the period minus one, 1 stages the start offset, 2 stages the inclusive end (end time minus one), and 3 loads the destination tag.
- R3: On each cycle with us_tick high, a slice counter increments. When it is already at or above the active period value, it returns to 0 instead, so one cycle lasts period+1 ticks.
- R4: slice_gate[i] is 1 exactly when start <= count <= end for slice i's active values, in the same cycle as the count.
- R5: Staged period, start and end values take effect only on the tick that wraps that slice's counter. A wrap in the same cycle as a write uses the value staged before that write.
- R6: A write with wr_slice 4 clears all four counters and activates all staged timing values on that edge, whatever wr_field and wr_data hold. It takes priority over a simultaneous tick.
- R7: A write with wr_slice 5, 6 or 7 changes nothing.
- R8: pkt_slice is the lowest-index slice whose tag equals pkt_tag, or 0 when no slice's tag equals pkt_tag.
- R9: pkt_permit is high only when pkt_valid is high and slice_gate[pkt_slice] is 1.
- R10: Without a tick and without a write, every gate holds its value.
- R11: A tag write is used for matching from the very next cycle, with no wait for a wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse each microsecond |
| wr_en | input | 1 | Write strobe |
| wr_slice | input | 3 | Slice index 0..3, 4 = synchronize, 5..7 ignored |
| wr_field | input | 2 | 0 period-1, 1 start, 2 end-1, 3 tag |
| wr_data | input | 32 | Write value (timing fields use the low 20 bits) |
| pkt_valid | input | 1 | A packet is presented |
| pkt_tag | input | 32 | Low 32 bits of the packet's destination address |
| slice_gate | output | 4 | Per-slice window open |
| pkt_permit | output | 1 | Presented packet may start now |
| pkt_slice | output | 2 | Slice governing the presented packet |

## Verification
The assertions assume that us_tick and wr_en are ordinary single-cycle strobes sampled on the clock. They also assume the gates may change only on a tick or a write, so a hold or an ignored index must leave slice_gate unchanged on the next edge. The stimulus drives every input on the falling edge. It never issues a write on a cycle that it labels as a hold. It keeps all programmed periods far below the 20-bit counter range. Ticks arrive on most cycles, so that wraps, staged updates and windows where start exceeds end all occur within a short run.

// File: rtl/tx_slice_gate_pkg.sv
package tx_slice_gate_pkg;

    typedef enum logic [1:0] {
        PH_BEFORE = 2'd0,
        PH_OPEN   = 2'd1,
        PH_AFTER  = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        FLD_PERIOD = 2'd0,
        FLD_START  = 2'd1,
        FLD_END    = 2'd2,
        FLD_TAG    = 2'd3
    } field_e;

endpackage

// File: rtl/slice_timer.sv
module slice_timer
    import tx_slice_gate_pkg::*;
#(
    parameter int CNT_W = 20,
    parameter int TAG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             sync,
    input  logic             wr_hit,
    input  logic [1:0]       wr_field,
    input  logic [TAG_W-1:0] wr_data,
    output logic             gate,
    output logic [TAG_W-1:0] tag
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] per_a, st_a, end_a;
    logic [CNT_W-1:0] per_d, st_d, end_d;
    logic [CNT_W-1:0] per_p, st_p, end_p;
    logic [TAG_W-1:0] tag_q;
    phase_e           ph_q, ph_d;

    // next count and active timing: synchronize beats tick
    always_comb begin
        cnt_d = cnt_q;
        per_d = per_a;
        st_d  = st_a;
        end_d = end_a;
        if (sync) begin
            cnt_d = '0;
            per_d = per_p;
            st_d  = st_p;
            end_d = end_p;
        end else if (tick) begin
            if (cnt_q >= per_a) begin
                cnt_d = '0;
                per_d = per_p;
                st_d  = st_p;
                end_d = end_p;
            end else begin
                cnt_d = cnt_q + CNT_W'(1);
            end
        end
    end

    // phase of the next count
    always_comb begin
        if (cnt_d < st_d)
            ph_d = PH_BEFORE;
        else if (cnt_d <= end_d)
            ph_d = PH_OPEN;
        else
            ph_d = PH_AFTER;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q  <= PH_OPEN;
            cnt_q <= '0;
            per_a <= '0;
            st_a  <= '0;
            end_a <= '0;
        end else begin
            ph_q  <= ph_d;
            cnt_q <= cnt_d;
            per_a <= per_d;
            st_a  <= st_d;
            end_a <= end_d;
        end
    end

    // staged timing and immediate tag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            per_p <= '0;
            st_p  <= '0;
            end_p <= '0;
            tag_q <= '0;
        end else if (wr_hit) begin
            unique case (field_e'(wr_field))
                FLD_PERIOD: per_p <= wr_data[CNT_W-1:0];
                FLD_START:  st_p  <= wr_data[CNT_W-1:0];
                FLD_END:    end_p <= wr_data[CNT_W-1:0];
                FLD_TAG:    tag_q <= wr_data;
                default:    tag_q <= tag_q;
            endcase
        end
    end

    // outputs
    always_comb begin
        unique case (ph_q)
            PH_OPEN:   gate = 1'b1;
            PH_BEFORE: gate = 1'b0;
            PH_AFTER:  gate = 1'b0;
            default:   gate = 1'b0;
        endcase
        tag = tag_q;
    end

endmodule

// File: rtl/slice_match.sv
module slice_match #(
    parameter int SLICE_N = 4,
    parameter int TAG_W   = 32,
    parameter int IDX_W   = 2
) (
    input  logic [TAG_W-1:0] tags [SLICE_N],
    input  logic [TAG_W-1:0] pkt_tag,
    output logic [IDX_W-1:0] sel
);

    // scan from the top so the lowest matching index is left standing
    always_comb begin
        sel = '0;
        for (int i = SLICE_N - 1; i >= 0; i--) begin
            if (tags[i] == pkt_tag)
                sel = IDX_W'(i);
        end
    end

endmodule

// File: rtl/tx_slice_gate.sv
module tx_slice_gate #(
    parameter int SLICE_N = 4,
    parameter int CNT_W   = 20,
    parameter int TAG_W   = 32,
    localparam int IDX_W  = $clog2(SLICE_N),
    localparam int WI_W   = $clog2(SLICE_N + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             us_tick,
    input  logic             wr_en,
    input  logic [WI_W-1:0]  wr_slice,
    input  logic [1:0]       wr_field,
    input  logic [TAG_W-1:0] wr_data,
    input  logic             pkt_valid,
    input  logic [TAG_W-1:0] pkt_tag,
    output logic [SLICE_N-1:0] slice_gate,
    output logic             pkt_permit,
    output logic [IDX_W-1:0] pkt_slice
);

    logic             sync_all;
    logic [TAG_W-1:0] tag_w [SLICE_N];

    assign sync_all = wr_en && (wr_slice == WI_W'(SLICE_N));

    for (genvar g = 0; g < SLICE_N; g++) begin : g_slice
        logic hit;
        assign hit = wr_en && (wr_slice == WI_W'(g));
        slice_timer #(.CNT_W(CNT_W), .TAG_W(TAG_W)) u_timer (
            .clk      (clk),
            .rst_n    (rst_n),
            .tick     (us_tick),
            .sync     (sync_all),
            .wr_hit   (hit),
            .wr_field (wr_field),
            .wr_data  (wr_data),
            .gate     (slice_gate[g]),
            .tag      (tag_w[g])
        );
    end

    slice_match #(.SLICE_N(SLICE_N), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_match (
        .tags    (tag_w),
        .pkt_tag (pkt_tag),
        .sel     (pkt_slice)
    );

    always_comb pkt_permit = pkt_valid && slice_gate[pkt_slice];

endmodule

// File: rtl/tx_slice_gate_chk.sv
module tx_slice_gate_chk #(
    parameter int SLICE_N = 4,
    parameter int IDX_W   = 2,
    parameter int WI_W    = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               us_tick,
    input logic               wr_en,
    input logic [WI_W-1:0]    wr_slice,
    input logic               pkt_valid,
    input logic [SLICE_N-1:0] slice_gate,
    input logic               pkt_permit,
    input logic [IDX_W-1:0]   pkt_slice
);

    assert_permit_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_permit |-> (pkt_valid && slice_gate[pkt_slice]));

    assert_no_idle_permit_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pkt_valid |-> !pkt_permit);

    assert_gate_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!us_tick && !wr_en) |=> $stable(slice_gate));

    assert_bad_index_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_slice > WI_W'(SLICE_N)) && !us_tick) |=> $stable(slice_gate));

endmodule

bind tx_slice_gate tx_slice_gate_chk #(
    .SLICE_N (SLICE_N),
    .IDX_W   (IDX_W),
    .WI_W    (WI_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .us_tick    (us_tick),
    .wr_en      (wr_en),
    .wr_slice   (wr_slice),
    .pkt_valid  (pkt_valid),
    .slice_gate (slice_gate),
    .pkt_permit (pkt_permit),
    .pkt_slice  (pkt_slice)
);

// File: tb/tx_slice_gate_tb_top.sv
module tx_slice_gate_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        us_tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_slice = '0;
    logic [1:0]  wr_field = '0;
    logic [31:0] wr_data = '0;
    logic        pkt_valid = 1'b0;
    logic [31:0] pkt_tag = '0;
    logic [3:0]  slice_gate;
    logic        pkt_permit;
    logic [1:0]  pkt_slice;

    always #10 clk = ~clk;

    tx_slice_gate dut_i (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .wr_en(wr_en),
        .wr_slice(wr_slice), .wr_field(wr_field), .wr_data(wr_data),
        .pkt_valid(pkt_valid), .pkt_tag(pkt_tag), .slice_gate(slice_gate),
        .pkt_permit(pkt_permit), .pkt_slice(pkt_slice)
    );

    typedef struct {
        logic [3:0] gate;
        logic       permit;
        logic [1:0] sl;
        string      req;
    } exp_t;

    exp_t q[$];
    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // requirement-level reference state
    int          m_cnt[4], m_per[4], m_st[4], m_en[4];
    int          p_per[4], p_st[4], p_en[4];
    logic [31:0] m_tag[4];

    localparam logic [31:0] TAG_A = 32'hb94cb1c1;
    localparam logic [31:0] TAG_B = 32'h1ada2ef2;
    localparam logic [31:0] TAG_C = 32'h4433222a;
    localparam logic [31:0] TAG_D = 32'h0badf00d;
    localparam logic [31:0] TAG_X = 32'h12345678;

    task automatic step(input logic tk, input logic we, input logic [2:0] ws,
                        input logic [1:0] wf, input logic [31:0] wd,
                        input logic pv, input logic [31:0] pt, input string req);
        exp_t e;
        int   s;
        us_tick = tk; wr_en = we; wr_slice = ws; wr_field = wf; wr_data = wd;
        pkt_valid = pv; pkt_tag = pt;
        if (rst_n) begin
            if (we && ws == 3'd4) begin
                for (int i = 0; i < 4; i++) begin
                    m_cnt[i] = 0; m_per[i] = p_per[i]; m_st[i] = p_st[i]; m_en[i] = p_en[i];
                end
            end else if (tk) begin
                for (int i = 0; i < 4; i++) begin
                    if (m_cnt[i] >= m_per[i]) begin
                        m_cnt[i] = 0; m_per[i] = p_per[i]; m_st[i] = p_st[i]; m_en[i] = p_en[i];
                    end else m_cnt[i]++;
                end
            end
            if (we && ws < 3'd4) begin
                case (wf)
                    2'd0: p_per[ws] = int'(wd[19:0]);
                    2'd1: p_st[ws]  = int'(wd[19:0]);
                    2'd2: p_en[ws]  = int'(wd[19:0]);
                    default: m_tag[ws] = wd;
                endcase
            end
        end
        for (int i = 0; i < 4; i++)
            e.gate[i] = (m_cnt[i] >= m_st[i]) && (m_cnt[i] <= m_en[i]);
        s = 0;
        for (int i = 3; i >= 0; i--) if (m_tag[i] == pt) s = i;
        e.sl = 2'(s);
        e.permit = pv && e.gate[s];
        e.req = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] ws, input logic [1:0] wf, input logic [31:0] wd,
                      input string req);
        step(1'b0, 1'b1, ws, wf, wd, 1'b1, wd, req);
    endtask

    // monitor: compare after each rising edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #5;
            while (q.size() > 0) begin
                e = q.pop_front();
                checks++;
                if (slice_gate !== e.gate || pkt_permit !== e.permit || pkt_slice !== e.sl) begin
                    fails++;
                    $display("FAIL %s gate=%b permit=%b slice=%0d expected gate=%b permit=%b slice=%0d",
                             e.req, slice_gate, pkt_permit, pkt_slice, e.gate, e.permit, e.sl);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_cnt[i] = 0; m_per[i] = 0; m_st[i] = 0; m_en[i] = 0;
            p_per[i] = 0; p_st[i] = 0; p_en[i] = 0; m_tag[i] = '0;
        end
        @(negedge clk);
        // R1: reset state
        step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, 32'd0, "R1");
        step(1'b1, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, 32'd0, "R1");
        rst_n = 1'b1;
        step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, TAG_X, "R1");
        // R2/R5: staged timing writes leave gates untouched; R11 tags apply at once
        wr(3'd0, 2'd0, 32'd9,  "R5"); wr(3'd0, 2'd1, 32'd2, "R5"); wr(3'd0, 2'd2, 32'd5,  "R5");
        wr(3'd1, 2'd0, 32'd4,  "R5"); wr(3'd1, 2'd1, 32'd0, "R5"); wr(3'd1, 2'd2, 32'd1,  "R5");
        wr(3'd2, 2'd0, 32'd7,  "R5"); wr(3'd2, 2'd1, 32'd3, "R5"); wr(3'd2, 2'd2, 32'd3,  "R5");
        wr(3'd3, 2'd0, 32'd15, "R5"); wr(3'd3, 2'd1, 32'd10,"R5"); wr(3'd3, 2'd2, 32'd15, "R5");
        wr(3'd0, 2'd3, TAG_A, "R11"); wr(3'd1, 2'd3, TAG_B, "R11");
        wr(3'd2, 2'd3, TAG_C, "R11"); wr(3'd3, 2'd3, TAG_D, "R11");
        // R7: out-of-range indices
        step(1'b0, 1'b1, 3'd6, 2'd0, 32'd3, 1'b1, TAG_A, "R7");
        step(1'b0, 1'b1, 3'd5, 2'd2, 32'd0, 1'b1, TAG_B, "R7");
        step(1'b0, 1'b1, 3'd7, 2'd3, TAG_X, 1'b1, TAG_X, "R7");
        // R6: synchronize applies staged timing
        step(1'b0, 1'b1, 3'd4, 2'd3, 32'd77, 1'b1, TAG_A, "R6");
        // R2/R3/R4/R8/R9: free run
        for (int k = 0; k < 40; k++) begin
            logic [31:0] t;
            string r;
            case (k % 5)
                0: begin t = TAG_A; r = "R4"; end
                1: begin t = TAG_B; r = "R3"; end
                2: begin t = TAG_C; r = "R2"; end
                3: begin t = TAG_D; r = "R4"; end
                default: begin t = TAG_X; r = "R8"; end
            endcase
            step(1'b1, 1'b0, 3'd0, 2'd0, 32'd0, (k % 7) != 6, t, (k % 7) == 6 ? "R9" : r);
        end
        // R10: no tick, no write
        for (int k = 0; k < 3; k++)
            step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, TAG_D, "R10");
        // R5: new period for slice 1 waits for the wrap; write with tick in same cycle
        step(1'b1, 1'b1, 3'd1, 2'd0, 32'd2, 1'b1, TAG_B, "R5");
        for (int k = 0; k < 12; k++)
            step(1'b1, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, TAG_B, "R5");
        // R8: duplicate tag picks the lowest index
        wr(3'd3, 2'd3, TAG_A, "R8");
        for (int k = 0; k < 6; k++)
            step(1'b1, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, TAG_A, "R8");
        // R6: synchronize wins over a tick, after restaging slice 2 (start > end)
        wr(3'd2, 2'd1, 32'd6, "R5"); wr(3'd2, 2'd2, 32'd2, "R5");
        step(1'b1, 1'b1, 3'd4, 2'd0, 32'd0, 1'b1, TAG_C, "R6");
        for (int k = 0; k < 20; k++)
            step(1'b1, 1'b0, 3'd0, 2'd0, 32'd0, 1'b1, (k % 2) ? TAG_C : TAG_D, "R4");
        step(1'b0, 1'b0, 3'd0, 2'd0, 32'd0, 1'b0, 32'd0, "R9");
        @(negedge clk);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule